// File: doc/BRIEF.md
# Per-Pin Function Select and Override Multiplexer

This block sits between a set of pads and the peripherals that may own them. Each pin carries a control word whose 5-bit selector picks one of nine function sources. One source is a small software-driven GPIO block holding an output register, an output-enable register and a read-only input register, each with one bit per pin. The other eight sources are peripheral ports brought in as flat vectors.

Three independent 2-bit override fields act on the selected path. The first acts on the output value, the second on the output enable, and the third on the input coming back from the pad. Each override can pass the signal, invert it, force it to 0 or force it to 1. A per-pin pad word then gates the result: an output-disable bit blocks the driver, and an input-enable bit blocks the return path. The pad word also holds drive-strength, pull, slew and Schmitt settings, which the block stores for the analog pad and does not act on.

Software reaches every register through a single-cycle write port and a combinational read port. The datapath is purely combinational from the registers and pins to the pads and peripherals. It has no states, so the state-machine parts of the house style do not apply.

Top module: `gpio_pin_mux`

## Requirements
- R1: After reset, every pin is disconnected, so pad_out and pad_oe are 0. Each control word reads 0x1F, each pad word reads 0x55 (input enabled, output not disabled, 4 mA, pull-down), and periph_in and the input register read 0.
- R2: A selector of 0 to 8 other than 5 routes slot `sel` of the pin's peripheral group (bit pin*9+sel of periph_out and periph_oe) onto the pin's output path.
- R3: Selector 5 routes the pin's bit of the software output register (address 0x00) and the software output-enable register (address 0x04) onto the output path. Both registers read back what was written.
- R4: A selector of 9 to 0x1F feeds 0 as the output value and 0 as the enable, so with pass-through overrides the pin does not drive.
- R5: The output override (control bits 13:12) gives the source value for code 0, its inverse for 1, 0 for 2 and 1 for 3. The result appears on pad_out.
- R6: The enable override (control bits 15:14) gives the source enable for code 0, its inverse for 1, 0 for 2 and 1 for 3.
- R7: pad_oe equals the overridden enable AND NOT pad word bit 7 (output disable).
- R8: The input override (control bits 17:16) maps pad_in as code 0 pass, 1 invert, 2 force 0, 3 force 1. The result is then ANDed with pad word bit 6 (input enable).
- R9: Only slot `sel` of the pin's periph_in group receives the gated input. Every other slot is 0, and all slots are 0 when the selector is 9 or above.
- R10: The input register (address 0x08) shows the gated input for pins with selector 5 and 0 for all other pins. Writes to it are ignored and leave the output registers unchanged.
- R11: Control word bits other than 17:12 and 4:0 read as 0. The pad word stores the low 8 bits written, with drive strength in bits 5:4 and pull in bits 3:2, and reads them back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte address: 0x00 out, 0x04 enable, 0x08 input, then per pin control at CTRL_BASE+8*p and pad at CTRL_BASE+8*p+4 |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| periph_out | input | NPINS*9 | Peripheral output values, group of 9 per pin |
| periph_oe | input | NPINS*9 | Peripheral output enables, group of 9 per pin |
| periph_in | output | NPINS*9 | Input delivered to each peripheral slot |
| pad_in | input | NPINS | Value sensed at each pad |
| pad_out | output | NPINS | Value driven to each pad |
| pad_oe | output | NPINS | Driver enable for each pad |

## Verification
The corner that is hardest to reach from the ports is the interaction of the three overrides with the two pad gates on a pin whose selector is invalid. Here the source contributes nothing, and only a forced enable or a forced input can make the pin visible. The bench reaches it by sweeping every selector code, 0 to 31, against all sixteen output and enable override pairs on every pin, with two different peripheral patterns per setting. A second sweep crosses selectors with every input override code, both input-enable states and both pad levels. In that sweep the bench reads all nine peripheral slots and the input register for each setting.

// File: rtl/pinmux_pkg.sv
package pinmux_pkg;
    localparam int SEL_W    = 5;
    localparam int NUM_SRC  = 9;
    localparam int GPIO_SRC = 5;
    localparam logic [SEL_W-1:0] SEL_NONE = 5'h1F;

    localparam int PAD_IE_BIT = 6;
    localparam int PAD_OD_BIT = 7;
    localparam logic [7:0] PAD_RESET = 8'h55;

    typedef enum logic [1:0] {
        OV_PASS = 2'd0,
        OV_INV  = 2'd1,
        OV_LOW  = 2'd2,
        OV_HIGH = 2'd3
    } ovr_e;

    typedef struct packed {
        ovr_e             in_ov;
        ovr_e             oe_ov;
        ovr_e             out_ov;
        logic [SEL_W-1:0] sel;
    } pin_cfg_t;

    localparam int CFG_W = $bits(pin_cfg_t);

    function automatic logic apply_ovr(input logic v, input ovr_e code);
        logic r;
        unique case (code)
            OV_PASS: r = v;
            OV_INV:  r = ~v;
            OV_LOW:  r = 1'b0;
            OV_HIGH: r = 1'b1;
            default: r = 1'b0;
        endcase
        return r;
    endfunction

    function automatic logic [31:0] cfg_to_word(input pin_cfg_t c);
        return {14'b0, c.in_ov, c.oe_ov, c.out_ov, 7'b0, c.sel};
    endfunction

    function automatic pin_cfg_t word_to_cfg(input logic [31:0] w);
        pin_cfg_t c;
        c.sel    = w[4:0];
        c.out_ov = ovr_e'(w[13:12]);
        c.oe_ov  = ovr_e'(w[15:14]);
        c.in_ov  = ovr_e'(w[17:16]);
        return c;
    endfunction
endpackage

// File: rtl/pinmux_regs.sv
module pinmux_regs
    import pinmux_pkg::*;
#(
    parameter int NPINS     = 4,
    parameter int ADDR_W    = 8,
    parameter int CTRL_BASE = 'h40
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [31:0]             wdata,
    input  logic [NPINS-1:0]        sw_in,
    output logic [31:0]             rdata,
    output pin_cfg_t [NPINS-1:0]    cfg_o,
    output logic [NPINS-1:0][7:0]   pad_o,
    output logic [NPINS-1:0]        sw_out_o,
    output logic [NPINS-1:0]        sw_oe_o
);
    localparam logic [ADDR_W-1:0] A_OUT  = ADDR_W'('h00);
    localparam logic [ADDR_W-1:0] A_OE   = ADDR_W'('h04);
    localparam logic [ADDR_W-1:0] A_IN   = ADDR_W'('h08);
    localparam logic [ADDR_W-1:0] A_BASE = ADDR_W'(CTRL_BASE);
    localparam pin_cfg_t CFG_RESET = '{in_ov: OV_PASS, oe_ov: OV_PASS,
                                       out_ov: OV_PASS, sel: SEL_NONE};

    logic [ADDR_W-1:0] rel;
    int                win_idx;
    logic              in_win;
    logic              is_pad;
    logic              unused_wbits;

    assign rel     = addr - A_BASE;
    assign win_idx = int'(rel >> 3);
    assign in_win  = (addr >= A_BASE) && (win_idx < NPINS) && (addr[1:0] == 2'b00);
    assign is_pad  = rel[2];
    assign unused_wbits = ^{wdata[31:18], wdata[11:5]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sw_out_o <= '0;
            sw_oe_o  <= '0;
        end else if (we) begin
            if (addr == A_OUT) sw_out_o <= wdata[NPINS-1:0];
            if (addr == A_OE)  sw_oe_o  <= wdata[NPINS-1:0];
        end
    end

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cfg_o[p] <= CFG_RESET;
                pad_o[p] <= PAD_RESET;
            end else if (we && in_win && (win_idx == p)) begin
                if (is_pad) pad_o[p] <= wdata[7:0];
                else        cfg_o[p] <= word_to_cfg(wdata);
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == A_OUT)      rdata[NPINS-1:0] = sw_out_o;
        else if (addr == A_OE)  rdata[NPINS-1:0] = sw_oe_o;
        else if (addr == A_IN)  rdata[NPINS-1:0] = sw_in;
        else if (in_win) begin
            for (int p = 0; p < NPINS; p++) begin
                if (win_idx == p) begin
                    if (is_pad) rdata = {24'b0, pad_o[p]};
                    else        rdata = cfg_to_word(cfg_o[p]);
                end
            end
        end
    end
endmodule

// File: rtl/pinmux_lane.sv
module pinmux_lane
    import pinmux_pkg::*;
(
    input  pin_cfg_t             cfg,
    input  logic [7:0]           pad_word,
    input  logic [NUM_SRC-1:0]   src_out,
    input  logic [NUM_SRC-1:0]   src_oe,
    input  logic                 sw_out,
    input  logic                 sw_oe,
    input  logic                 pad_in,
    output logic                 pad_out,
    output logic                 pad_oe,
    output logic [NUM_SRC-1:0]   src_in,
    output logic                 sw_in
);
    logic pick_out, pick_oe, in_val, unused_pad;

    assign unused_pad = ^pad_word[5:0];

    always_comb begin
        pick_out = 1'b0;
        pick_oe  = 1'b0;
        for (int f = 0; f < NUM_SRC; f++) begin
            if (cfg.sel == SEL_W'(f)) begin
                if (f == GPIO_SRC) begin
                    pick_out = sw_out;
                    pick_oe  = sw_oe;
                end else begin
                    pick_out = src_out[f];
                    pick_oe  = src_oe[f];
                end
            end
        end
    end

    assign pad_out = apply_ovr(pick_out, cfg.out_ov);
    assign pad_oe  = apply_ovr(pick_oe, cfg.oe_ov) & ~pad_word[PAD_OD_BIT];
    assign in_val  = apply_ovr(pad_in, cfg.in_ov) & pad_word[PAD_IE_BIT];

    always_comb begin
        for (int f = 0; f < NUM_SRC; f++)
            src_in[f] = (cfg.sel == SEL_W'(f)) ? in_val : 1'b0;
    end

    assign sw_in = (cfg.sel == SEL_W'(GPIO_SRC)) ? in_val : 1'b0;
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux
    import pinmux_pkg::*;
#(
    parameter int NPINS     = 4,
    parameter int ADDR_W    = 8,
    parameter int CTRL_BASE = 'h40
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       reg_we,
    input  logic [ADDR_W-1:0]          reg_addr,
    input  logic [31:0]                reg_wdata,
    output logic [31:0]                reg_rdata,
    input  logic [NPINS*NUM_SRC-1:0]   periph_out,
    input  logic [NPINS*NUM_SRC-1:0]   periph_oe,
    output logic [NPINS*NUM_SRC-1:0]   periph_in,
    input  logic [NPINS-1:0]           pad_in,
    output logic [NPINS-1:0]           pad_out,
    output logic [NPINS-1:0]           pad_oe
);
    pin_cfg_t [NPINS-1:0]      cfg_q;
    logic [NPINS-1:0][7:0]     pad_q;
    logic [NPINS-1:0]          sw_out_q, sw_oe_q, sw_in_w;

    pinmux_regs #(.NPINS(NPINS), .ADDR_W(ADDR_W), .CTRL_BASE(CTRL_BASE)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (reg_we),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .sw_in    (sw_in_w),
        .rdata    (reg_rdata),
        .cfg_o    (cfg_q),
        .pad_o    (pad_q),
        .sw_out_o (sw_out_q),
        .sw_oe_o  (sw_oe_q)
    );

    for (genvar p = 0; p < NPINS; p++) begin : g_lane
        pinmux_lane u_lane (
            .cfg      (cfg_q[p]),
            .pad_word (pad_q[p]),
            .src_out  (periph_out[p*NUM_SRC +: NUM_SRC]),
            .src_oe   (periph_oe[p*NUM_SRC +: NUM_SRC]),
            .sw_out   (sw_out_q[p]),
            .sw_oe    (sw_oe_q[p]),
            .pad_in   (pad_in[p]),
            .pad_out  (pad_out[p]),
            .pad_oe   (pad_oe[p]),
            .src_in   (periph_in[p*NUM_SRC +: NUM_SRC]),
            .sw_in    (sw_in_w[p])
        );
    end
endmodule

// File: rtl/pinmux_chk.sv
module pinmux_chk
    import pinmux_pkg::*;
#(
    parameter int NPINS  = 4,
    parameter int ADDR_W = 8
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     reg_we,
    input logic [ADDR_W-1:0]        reg_addr,
    input logic [NPINS-1:0]         pad_oe,
    input logic [NPINS*NUM_SRC-1:0] periph_in,
    input logic [NPINS*CFG_W-1:0]   cfg_flat,
    input logic [NPINS*8-1:0]       pad_flat,
    input logic [NPINS-1:0]         sw_out
);
    // R10
    in_reg_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == ADDR_W'('h08)) |=> $stable(sw_out));

    for (genvar p = 0; p < NPINS; p++) begin : g_chk
        logic [SEL_W-1:0] sel_w;
        logic [1:0]       oe_ov_w;
        assign sel_w   = cfg_flat[p*CFG_W +: SEL_W];
        assign oe_ov_w = cfg_flat[p*CFG_W + SEL_W + 2 +: 2];

        // R7
        out_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
            pad_flat[p*8 + PAD_OD_BIT] |-> !pad_oe[p]);

        // R8
        in_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !pad_flat[p*8 + PAD_IE_BIT] |-> ($countones(periph_in[p*NUM_SRC +: NUM_SRC]) == 0));

        // R9
        one_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(periph_in[p*NUM_SRC +: NUM_SRC]));

        // R4
        no_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (sel_w >= SEL_W'(NUM_SRC) && oe_ov_w == 2'd0) |-> !pad_oe[p]);
    end
endmodule

bind gpio_pin_mux pinmux_chk #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .pad_oe    (pad_oe),
    .periph_in (periph_in),
    .cfg_flat  (cfg_q),
    .pad_flat  (pad_q),
    .sw_out    (sw_out_q)
);

// File: tb/sim_gpio_pin_mux.sv
`timescale 1ns/1ps
module sim_gpio_pin_mux;
    localparam int NP = 4;
    localparam int NS = 9;
    localparam int AW = 8;
    localparam int BASE = 'h40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_we = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [NP*NS-1:0] periph_out = '0, periph_oe = '0, periph_in;
    logic [NP-1:0] pad_in = '0, pad_out, pad_oe;

    int n_chk = 0;
    int n_bad = 0;
    logic [NP-1:0] sw_o_m, sw_e_m;

    always #5 clk = ~clk;

    gpio_pin_mux #(.NPINS(NP), .ADDR_W(AW), .CTRL_BASE(BASE)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .periph_out(periph_out), .periph_oe(periph_oe), .periph_in(periph_in),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe));

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = AW'(a); reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
        #1;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = AW'(a);
        #1 d = reg_rdata;
    endtask

    function automatic logic ovr(input logic v, input int c);
        case (c)
            0: return v;
            1: return ~v;
            2: return 1'b0;
            default: return 1'b1;
        endcase
    endfunction

    function automatic logic [31:0] ctrl_word(input int sel, input int oo, input int eo, input int io);
        return (32'(io) << 16) | (32'(eo) << 14) | (32'(oo) << 12) | 32'(sel);
    endfunction

    task automatic set_pat(input int k);
        for (int i = 0; i < NP*NS; i++) begin
            periph_out[i] = (((i*7 + k) % 3) == 0);
            periph_oe[i]  = (((i*5 + k) % 2) == 1);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic so, se, eo_exp, ein;
        string tg;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;

        // R1 reset state
        chk("R1 pad_oe", pad_oe, 0);
        chk("R1 pad_out", pad_out, 0);
        chk("R1 periph_in", periph_in, 0);
        for (int p = 0; p < NP; p++) begin
            rd(BASE + 8*p, d);     chk("R1 ctrl", d, 32'h1F);
            rd(BASE + 8*p + 4, d); chk("R1 pad", d, 32'h55);
        end
        rd(8, d); chk("R1 input reg", d, 0);

        // R3 software registers
        sw_o_m = 4'b0101; sw_e_m = 4'b0011;
        wr(0, 32'(sw_o_m));
        wr(4, 32'(sw_e_m));
        rd(0, d); chk("R3 out readback", d, 32'(sw_o_m));
        rd(4, d); chk("R3 oe readback", d, 32'(sw_e_m));

        // R2 R3 R4 R5 R6: output path sweep
        for (int p = 0; p < NP; p++)
            for (int sel = 0; sel < 32; sel++)
                for (int oo = 0; oo < 4; oo++)
                    for (int eo = 0; eo < 4; eo++) begin
                        wr(BASE + 8*p, ctrl_word(sel, oo, eo, 0));
                        for (int k = 0; k < 2; k++) begin
                            set_pat(k + sel);
                            #1;
                            if (sel == 5) begin
                                so = sw_o_m[p]; se = sw_e_m[p]; tg = "R3";
                            end else if (sel < NS) begin
                                so = periph_out[p*NS + sel]; se = periph_oe[p*NS + sel]; tg = "R2";
                            end else begin
                                so = 1'b0; se = 1'b0; tg = "R4";
                            end
                            chk({tg, " R5 pad_out"}, pad_out[p], ovr(so, oo));
                            chk({tg, " R6 pad_oe"}, pad_oe[p], ovr(se, eo));
                        end
                    end

        // R7 output disable
        for (int p = 0; p < NP; p++) begin
            wr(BASE + 8*p, ctrl_word(5, 3, 3, 0));
            wr(BASE + 8*p + 4, 32'hD5);
            chk("R7 disabled", pad_oe[p], 1'b0);
            chk("R7 value kept", pad_out[p], 1'b1);
            wr(BASE + 8*p + 4, 32'h55);
            chk("R7 enabled", pad_oe[p], 1'b1);
        end

        // R8 R9 R10: input path sweep
        for (int p = 0; p < NP; p++)
            for (int sel = 0; sel < 11; sel++)
                for (int io = 0; io < 4; io++)
                    for (int ie = 0; ie < 2; ie++) begin
                        automatic int s = (sel == 10) ? 31 : sel;
                        wr(BASE + 8*p, ctrl_word(s, 0, 0, io));
                        wr(BASE + 8*p + 4, ie ? 32'h55 : 32'h15);
                        for (int v = 0; v < 2; v++) begin
                            pad_in = '0;
                            pad_in[p] = v[0];
                            #1;
                            ein = ovr(v[0], io) & ie[0];
                            for (int f = 0; f < NS; f++)
                                chk((f == s) ? "R8 selected slot" : "R9 other slot",
                                    periph_in[p*NS + f], (f == s) ? ein : 1'b0);
                            rd(8, d);
                            chk("R10 input reg", d[p], (s == 5) ? ein : 1'b0);
                        end
                    end
        pad_in = '0;
        for (int p = 0; p < NP; p++) wr(BASE + 8*p + 4, 32'h55);

        // R10 write to input register ignored
        for (int p = 0; p < NP; p++) wr(BASE + 8*p, ctrl_word(5, 0, 3, 0));
        wr(8, 32'hFFFF_FFFF);
        rd(0, d); chk("R10 out unchanged", d, 32'(sw_o_m));
        rd(4, d); chk("R10 oe unchanged", d, 32'(sw_e_m));
        chk("R10 pad_out unchanged", pad_out, sw_o_m);
        pad_in = 4'b1001;
        rd(8, d); chk("R10 input follows pads", d, 32'h9);
        pad_in = '0;

        // R11 readback masking
        wr(BASE + 8, 32'hFFFF_FFFF);
        rd(BASE + 8, d); chk("R11 ctrl mask", d, 32'h0003_F01F);
        wr(BASE + 12, 32'h1234_5678);
        rd(BASE + 12, d); chk("R11 pad store", d, 32'h78);
        wr(BASE + 12, 32'h0000_0038);
        rd(BASE + 12, d); chk("R11 drive/pull bits", d[5:2], 4'b1110);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule